// File: doc/BRIEF.md
# Indirect CSR Front End for a Network Controller

This block is the register face of a network controller. A host reaches four control and status registers through two word-wide ports. The index port holds a pointer that selects one of the four registers. The data port reads or writes whichever register that pointer selects. Register 0 is the command and status word. Registers 1 and 2 hold the low 16 bits and the upper bits of the setup-block address. Register 3 holds three bus-mode bits. The block produces single-cycle stop, initialize, start and transmit-demand commands toward the engine behind it. It also produces one interrupt line. It takes single-cycle event pulses for receive, transmit and four error causes.

After reset the controller is stopped. Software programs registers 1 to 3 while the controller is stopped. It then sets the initialize bit and waits for the init-done flag. A built-in counter raises that flag a fixed `INIT_LAT` cycles later, in place of the fetch of the setup block. Software then writes init-done together with start, which clears the flag and starts the engine.

The host interface is a plain strobe bus with no back-pressure. A write takes effect at the clock edge where `host_wr` is high. `host_rdata` always shows the port chosen by `host_sel`, so a read needs no strobe and takes no cycle.

Top module: `lnc_csr_front`

## Requirements
- R1: After reset, register 0 reads 0x0004, so only the stopped bit (bit 2) is set. The pointer reads 0, registers 1 to 3 read 0 and `irq` is low.
- R2: A write with `host_sel`=0 loads the pointer from `host_wdata[1:0]`. Reading with `host_sel`=0 returns the pointer zero-extended. Reads and writes with `host_sel`=1 go to the register the pointer selects.
- R3: Writing register 0 with bit 2 set does the following in the write cycle:
  - it pulses `eng_stop`;
  - it suppresses the start and initialize commands of the same write;
  - it clears every other bit of register 0, which then reads exactly 0x0004.
- R4: Writing register 0 with bit 0 set and bit 2 clear does the following:
  - it pulses `eng_init` in the write cycle;
  - it clears the stopped bit and sets bit 0;
  - it raises init-done (bit 8) exactly `INIT_LAT` clock edges after the write edge.
  A stop issued before that edge cancels the pending init-done.
- R5: Writing register 0 with bit 1 set and bit 2 clear does the following:
  - it pulses `eng_start` in the write cycle;
  - it sets start (bit 1), receiver-on (bit 5) and transmitter-on (bit 4);
  - it clears the stopped bit.
  Writing 0 to bits 0 to 3 has no effect.
- R6: Status bits 14 down to 8 are write-one-to-clear: babble, collision, missed, memory, receive, transmit and init-done. Writing 0 to a status bit leaves it unchanged. An event that arrives in the same cycle as the clear wins.
- R7: While the controller runs, event pulses set their status bits: `evt_babl` sets bit 14, `evt_cerr` bit 13, `evt_miss` bit 12, `evt_merr` bit 11, `evt_rint` bit 10 and `evt_tint` bit 9. While it is stopped, events are ignored.
- R8: Bit 15 (error summary) reads as the OR of bits 14 to 11. Bit 7 (interrupt summary) reads as the OR of bit 15, bit 10, bit 9 and bit 8.
- R9: Bit 6 (interrupt enable) is loaded by every register 0 write that does not stop. `irq` is high exactly when bit 7 and bit 6 are both set.
- R10: Writes to registers 1 to 3 take effect only while stopped. Otherwise they are ignored. Register 2 keeps the low `HI_W` bits and register 3 keeps bits 2:0. `init_blk_addr` is {register 2, register 1}. `cfg_byte_swap`, `cfg_ale_ctl` and `cfg_byte_ctl` are register 3 bits 2, 1 and 0.
- R11: Writing register 0 with bit 3 set pulses `eng_tx_demand` only while start is set and the write does not stop. Bit 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Write strobe |
| host_sel | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected port |
| evt_rint | input | 1 | Receive event pulse |
| evt_tint | input | 1 | Transmit event pulse |
| evt_babl | input | 1 | Babble error pulse |
| evt_cerr | input | 1 | Collision error pulse |
| evt_miss | input | 1 | Missed frame pulse |
| evt_merr | input | 1 | Memory error pulse |
| eng_init | output | 1 | Initialize command pulse |
| eng_start | output | 1 | Start command pulse |
| eng_stop | output | 1 | Stop command pulse |
| eng_tx_demand | output | 1 | Transmit demand pulse |
| init_blk_addr | output | 16+HI_W | Setup-block address |
| cfg_byte_swap | output | 1 | Byte-swap mode |
| cfg_ale_ctl | output | 1 | Address-latch control mode |
| cfg_byte_ctl | output | 1 | Byte control mode |
| irq | output | 1 | Interrupt request |

## Verification
The bench times init-done to the exact edge: a design that counts one edge short or long reads 0x01C1 at the wrong sample. It also checks that a stop issued mid-count leaves register 0 at 0x0004.

A stop written together with start must give a stop pulse and no start pulse. A merged command decoder fails this.

An event and its own clear in the same cycle must leave the bit set. A design that lets the clear win drops an interrupt.

Writes to the address registers while running must read back unchanged. A design without the lock corrupts the setup address under a live engine. Clearing one of two pending errors must keep the error summary high.

// File: rtl/lnc_pkg.sv
package lnc_pkg;
  localparam int DW = 16;
  localparam int NFLAG = 7;
  localparam int FLAG_LSB = 8;   // status flags occupy bits 14:8
  localparam int B_ERR  = 15;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_TDMD = 3;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;
  // flag indices inside the status vector
  localparam int F_IDON = 0;
  localparam int F_TINT = 1;
  localparam int F_RINT = 2;
  localparam int F_MERR = 3;
  localparam int F_MISS = 4;
  localparam int F_CERR = 5;
  localparam int F_BABL = 6;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_ALO  = 2'd1,
    REG_AHI  = 2'd2,
    REG_MODE = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic babl;
    logic cerr;
    logic miss;
    logic merr;
    logic rint;
    logic tint;
  } lnc_evt_t;
endpackage

// File: rtl/lnc_flags.sv
module lnc_flags #(
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [NF-1:0] set_v,
  input  logic [NF-1:0] clr_v,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= 1'b0;
      else if (flush)     q[i] <= 1'b0;
      else if (set_v[i])  q[i] <= 1'b1;
      else if (clr_v[i])  q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lnc_ctrl.sv
module lnc_ctrl
  import lnc_pkg::*;
#(
  parameter int INIT_LAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  output logic          stop_q,
  output logic          init_q,
  output logic          strt_q,
  output logic          rxon_q,
  output logic          txon_q,
  output logic          inea_q,
  output logic          stop_req,
  output logic          init_req,
  output logic          strt_req,
  output logic          tdmd_req,
  output logic          idon_set
);
  localparam int TW = $clog2(INIT_LAT + 1);
  localparam logic [TW-1:0] LAT = TW'(INIT_LAT);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] timer_q;

  assign stop_req = wr_cmd && wdata[B_STOP];
  assign init_req = wr_cmd && wdata[B_INIT] && !wdata[B_STOP];
  assign strt_req = wr_cmd && wdata[B_STRT] && !wdata[B_STOP];
  assign tdmd_req = wr_cmd && wdata[B_TDMD] && !wdata[B_STOP] && strt_q;
  assign idon_set = (timer_q == ONE) && !stop_req && !init_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b1;
      init_q  <= 1'b0;
      strt_q  <= 1'b0;
      rxon_q  <= 1'b0;
      txon_q  <= 1'b0;
      inea_q  <= 1'b0;
      timer_q <= '0;
    end else if (stop_req) begin
      stop_q  <= 1'b1;
      init_q  <= 1'b0;
      strt_q  <= 1'b0;
      rxon_q  <= 1'b0;
      txon_q  <= 1'b0;
      inea_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      if (wr_cmd) inea_q <= wdata[B_INEA];
      if (init_req) begin
        init_q  <= 1'b1;
        stop_q  <= 1'b0;
        timer_q <= LAT;
      end else if (timer_q != '0) begin
        timer_q <= timer_q - ONE;
      end
      if (strt_req) begin
        strt_q <= 1'b1;
        rxon_q <= 1'b1;
        txon_q <= 1'b1;
        stop_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lnc_cfg.sv
module lnc_cfg
  import lnc_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_data,
  input  logic            unlocked,
  input  reg_idx_e        idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   addr_lo,
  output logic [HI_W-1:0] addr_hi,
  output logic [2:0]      mode
);
  logic wr_ok;
  assign wr_ok = wr_data && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= '0;
      mode    <= '0;
    end else if (wr_ok) begin
      case (idx)
        REG_ALO:  addr_lo <= wdata;
        REG_AHI:  addr_hi <= wdata[HI_W-1:0];
        REG_MODE: mode    <= wdata[2:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/lnc_csr_front.sv
module lnc_csr_front
  import lnc_pkg::*;
#(
  parameter int INIT_LAT = 8,
  parameter int HI_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_sel,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  input  logic               evt_rint,
  input  logic               evt_tint,
  input  logic               evt_babl,
  input  logic               evt_cerr,
  input  logic               evt_miss,
  input  logic               evt_merr,
  output logic               eng_init,
  output logic               eng_start,
  output logic               eng_stop,
  output logic               eng_tx_demand,
  output logic [16+HI_W-1:0] init_blk_addr,
  output logic               cfg_byte_swap,
  output logic               cfg_ale_ctl,
  output logic               cfg_byte_ctl,
  output logic               irq
);
  reg_idx_e         ptr_q;
  logic             wr_cmd, wr_data;
  logic             st_stop, st_init, st_strt, st_rxon, st_txon, st_inea;
  logic             stop_req, init_req, strt_req, tdmd_req, idon_set;
  logic [NFLAG-1:0] flags, set_v, clr_v;
  logic [DW-1:0]    addr_lo;
  logic [HI_W-1:0]  addr_hi;
  logic [2:0]       mode;
  logic             err_sum, int_sum;
  logic [DW-1:0]    csr0_v;
  lnc_evt_t         evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ptr_q <= REG_CMD;
    else if (host_wr && !host_sel)  ptr_q <= reg_idx_e'(host_wdata[1:0]);
  end

  assign wr_data = host_wr && host_sel;
  assign wr_cmd  = wr_data && (ptr_q == REG_CMD);

  lnc_ctrl #(.INIT_LAT(INIT_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(host_wdata),
    .stop_q(st_stop), .init_q(st_init), .strt_q(st_strt),
    .rxon_q(st_rxon), .txon_q(st_txon), .inea_q(st_inea),
    .stop_req(stop_req), .init_req(init_req), .strt_req(strt_req),
    .tdmd_req(tdmd_req), .idon_set(idon_set)
  );

  assign evt = '{babl: evt_babl, cerr: evt_cerr, miss: evt_miss,
                 merr: evt_merr, rint: evt_rint, tint: evt_tint};

  always_comb begin
    set_v         = '0;
    set_v[F_IDON] = idon_set;
    if (!st_stop) begin
      set_v[F_TINT] = evt.tint;
      set_v[F_RINT] = evt.rint;
      set_v[F_MERR] = evt.merr;
      set_v[F_MISS] = evt.miss;
      set_v[F_CERR] = evt.cerr;
      set_v[F_BABL] = evt.babl;
    end
  end

  assign clr_v = wr_cmd ? host_wdata[FLAG_LSB +: NFLAG] : '0;

  lnc_flags #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(stop_req),
    .set_v(set_v), .clr_v(clr_v), .q(flags)
  );

  lnc_cfg #(.HI_W(HI_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .unlocked(st_stop),
    .idx(ptr_q), .wdata(host_wdata),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .mode(mode)
  );

  assign err_sum = |flags[F_BABL:F_MERR];
  assign int_sum = err_sum | flags[F_RINT] | flags[F_TINT] | flags[F_IDON];

  always_comb begin
    csr0_v                        = '0;
    csr0_v[B_ERR]                 = err_sum;
    csr0_v[FLAG_LSB +: NFLAG]     = flags;
    csr0_v[B_INTR]                = int_sum;
    csr0_v[B_INEA]                = st_inea;
    csr0_v[B_RXON]                = st_rxon;
    csr0_v[B_TXON]                = st_txon;
    csr0_v[B_STOP]                = st_stop;
    csr0_v[B_STRT]                = st_strt;
    csr0_v[B_INIT]                = st_init;
  end

  always_comb begin
    if (!host_sel) begin
      host_rdata = {14'd0, ptr_q};
    end else begin
      case (ptr_q)
        REG_CMD:  host_rdata = csr0_v;
        REG_ALO:  host_rdata = addr_lo;
        REG_AHI:  host_rdata = DW'(addr_hi);
        default:  host_rdata = {13'd0, mode};
      endcase
    end
  end

  assign eng_init      = init_req;
  assign eng_start     = strt_req;
  assign eng_stop      = stop_req;
  assign eng_tx_demand = tdmd_req;
  assign init_blk_addr = {addr_hi, addr_lo};
  assign cfg_byte_swap = mode[2];
  assign cfg_ale_ctl   = mode[1];
  assign cfg_byte_ctl  = mode[0];
  assign irq           = int_sum & st_inea;
endmodule

// File: rtl/lnc_csr_front_chk.sv
module lnc_csr_front_chk #(
  parameter int HI_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               eng_stop,
  input logic               eng_start,
  input logic               eng_tx_demand,
  input logic               irq,
  input logic               st_stop,
  input logic               st_strt,
  input logic               st_rxon,
  input logic               st_txon,
  input logic               st_inea,
  input logic               idon_flag,
  input logic [15:0]        csr0_v,
  input logic [16+HI_W-1:0] cfg_addr,
  input logic [2:0]         cfg_mode
);
  a_r3_stop_clean: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |=> (csr0_v == 16'h0004));
  a_r4_no_idon_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    st_stop |-> !idon_flag);
  a_r5_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> (st_rxon && st_txon && !st_stop));
  a_r9_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_inea);
  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !st_stop |=> ($stable(cfg_addr) && $stable(cfg_mode)));
  a_r11_tdmd_running: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_demand |-> st_strt);
endmodule

bind lnc_csr_front lnc_csr_front_chk #(.HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_stop(eng_stop), .eng_start(eng_start),
  .eng_tx_demand(eng_tx_demand), .irq(irq), .st_stop(st_stop),
  .st_strt(st_strt), .st_rxon(st_rxon), .st_txon(st_txon),
  .st_inea(st_inea), .idon_flag(flags[0]), .csr0_v(csr0_v),
  .cfg_addr(init_blk_addr), .cfg_mode(mode)
);

// File: tb/lnc_csr_front_tb.sv
module lnc_csr_front_tb;
  localparam int INIT_LAT = 8;
  localparam int HI_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_sel = 1'b0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic evt_rint = 0, evt_tint = 0, evt_babl = 0, evt_cerr = 0, evt_miss = 0, evt_merr = 0;
  logic eng_init, eng_start, eng_stop, eng_tx_demand;
  logic [16+HI_W-1:0] init_blk_addr;
  logic cfg_byte_swap, cfg_ale_ctl, cfg_byte_ctl, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic c_init, c_start, c_stop, c_tdmd;
  logic [15:0] exp_q[$];
  string tag_q[$];
  event mon_go, mon_done;

  always #4 clk = ~clk;

  lnc_csr_front #(.INIT_LAT(INIT_LAT), .HI_W(HI_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_rint(evt_rint), .evt_tint(evt_tint), .evt_babl(evt_babl),
    .evt_cerr(evt_cerr), .evt_miss(evt_miss), .evt_merr(evt_merr),
    .eng_init(eng_init), .eng_start(eng_start), .eng_stop(eng_stop),
    .eng_tx_demand(eng_tx_demand), .init_blk_addr(init_blk_addr),
    .cfg_byte_swap(cfg_byte_swap), .cfg_ale_ctl(cfg_ale_ctl),
    .cfg_byte_ctl(cfg_byte_ctl), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard and compares with the read port
  initial begin
    forever begin
      @(mon_go);
      #1;
      chk(tag_q.pop_front(), 32'(host_rdata), 32'(exp_q.pop_front()));
      -> mon_done;
    end
  end

  task automatic rd(input logic sel, input logic [15:0] exp, input string tag);
    host_sel = sel;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> mon_go;
    @(mon_done);
  endtask

  task automatic wr_ev(input logic sel, input logic [15:0] d, input logic [5:0] ev);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    {evt_babl, evt_cerr, evt_miss, evt_merr, evt_rint, evt_tint} = ev;
    #1;
    c_init = eng_init; c_start = eng_start; c_stop = eng_stop; c_tdmd = eng_tx_demand;
    @(negedge clk);
    host_wr = 1'b0;
    {evt_babl, evt_cerr, evt_miss, evt_merr, evt_rint, evt_tint} = '0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_ev(sel, d, 6'b0);
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    {evt_babl, evt_cerr, evt_miss, evt_merr, evt_rint, evt_tint} = ev;
    @(negedge clk);
    {evt_babl, evt_cerr, evt_miss, evt_merr, evt_rint, evt_tint} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b1, 16'h0004, "R1 csr0 reset");
    rd(1'b0, 16'h0000, "R1 pointer reset");
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 cfg reset", 32'(init_blk_addr), 0);
    // R10 configure while stopped, R2 pointer
    wr(1'b0, 16'h0001); rd(1'b0, 16'h0001, "R2 pointer readback");
    wr(1'b1, 16'hBEEF); rd(1'b1, 16'hBEEF, "R10 csr1 write stopped");
    wr(1'b0, 16'h0002); wr(1'b1, 16'h12AB); rd(1'b1, 16'h00AB, "R10 csr2 width");
    wr(1'b0, 16'h0003); wr(1'b1, 16'hFFFF); rd(1'b1, 16'h0007, "R10 csr3 bits");
    chk("R10 init_blk_addr", 32'(init_blk_addr), 32'h00ABBEEF);
    chk("R10 mode pins", 32'({cfg_byte_swap, cfg_ale_ctl, cfg_byte_ctl}), 7);
    wr(1'b0, 16'h0000);
    // R7 events ignored while stopped
    pulse(6'b000010);
    rd(1'b1, 16'h0004, "R7 event ignored stopped");
    // R4 init and timed init-done
    wr(1'b1, 16'h0041);
    chk("R4 eng_init pulse", 32'(c_init), 1);
    rd(1'b1, 16'h0041, "R4 init set");
    repeat (INIT_LAT - 1) @(negedge clk);
    rd(1'b1, 16'h0041, "R4 idon not early");
    @(negedge clk);
    rd(1'b1, 16'h01C1, "R4 idon on time");
    chk("R9 irq on idon", 32'(irq), 1);
    // R10 locked while running
    wr(1'b0, 16'h0001); wr(1'b1, 16'h1111);
    rd(1'b1, 16'hBEEF, "R10 csr1 locked");
    wr(1'b0, 16'h0000);
    // R5 start
    wr(1'b1, 16'h0142);
    chk("R5 eng_start pulse", 32'(c_start), 1);
    rd(1'b1, 16'h0073, "R5 running state");
    chk("R9 irq cleared", 32'(irq), 0);
    // R6 W1C, R7 events, R8 summaries
    pulse(6'b000010);
    rd(1'b1, 16'h04F3, "R7 rint set");
    wr(1'b1, 16'h0040);
    rd(1'b1, 16'h04F3, "R6 write zero keeps");
    wr(1'b1, 16'h0440);
    rd(1'b1, 16'h0073, "R6 rint cleared");
    pulse(6'b100000);
    rd(1'b1, 16'hC0F3, "R8 babble summary");
    wr(1'b1, 16'h4040);
    pulse(6'b000100);
    rd(1'b1, 16'h88F3, "R8 memory error summary");
    wr(1'b1, 16'h0840);
    pulse(6'b011000);
    rd(1'b1, 16'hB0F3, "R7 cerr and miss");
    wr(1'b1, 16'h2040);
    rd(1'b1, 16'h90F3, "R8 err held by miss");
    wr(1'b1, 16'h1040);
    rd(1'b1, 16'h0073, "R6 all errors cleared");
    // R9 enable off
    pulse(6'b000001);
    wr(1'b1, 16'h0000);
    rd(1'b1, 16'h02B3, "R9 inea cleared");
    chk("R9 irq masked", 32'(irq), 0);
    // R6 set wins over clear
    wr_ev(1'b1, 16'h0200, 6'b000001);
    rd(1'b1, 16'h02B3, "R6 event beats clear");
    wr(1'b1, 16'h0200);
    rd(1'b1, 16'h0033, "R6 tint cleared");
    // R11 transmit demand
    wr(1'b1, 16'h0008);
    chk("R11 tdmd pulse running", 32'(c_tdmd), 1);
    rd(1'b1, 16'h0033, "R11 tdmd reads zero");
    // R3 stop priority
    pulse(6'b000001);
    wr(1'b1, 16'h0046);
    chk("R3 eng_stop pulse", 32'(c_stop), 1);
    chk("R3 start suppressed", 32'(c_start), 0);
    rd(1'b1, 16'h0004, "R3 stop value");
    chk("R3 irq low", 32'(irq), 0);
    wr(1'b1, 16'h0008);
    chk("R11 tdmd stopped", 32'(c_tdmd), 0);
    // R4 stop cancels pending init-done
    wr(1'b1, 16'h0001);
    repeat (3) @(negedge clk);
    wr(1'b1, 16'h0004);
    repeat (INIT_LAT + 2) @(negedge clk);
    rd(1'b1, 16'h0004, "R4 stop cancels idon");
    // R2 pointer takes low two bits
    wr(1'b0, 16'h0007);
    rd(1'b0, 16'h0003, "R2 pointer wrap");
    rd(1'b1, 16'h0007, "R2 data via wrapped pointer");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule